// File: doc/BRIEF.md
# FP32-to-BF16 Vector Narrowing Converter

This block takes a 128-bit vector holding four single-precision values and turns each into a 16-bit brain-float value. The sign and the full 8-bit exponent are kept, and the mantissa is rounded from 23 bits down to 7. The four narrow results are packed into a 64-bit half-vector. That half-vector is then merged with the previous contents of a 128-bit destination.

A one-bit half selector picks how the merge is done. In the low form, the packed result becomes the low half and the high half is cleared. In the high form, the packed result becomes the high half and the low half of the old destination is kept. A two-bit rounding control and a flush-to-zero control steer the conversion. Four exception flags (invalid, overflow, inexact, input-denormal) are ORed across the lanes.

The result and the flags are registered, so they appear one clock after an accepted operation.

Top module: `bf16_narrow_unit`

## Requirements
- R1: One clock after `in_valid` is high, `out_valid` is high and `dst_new` and the flags show that operation; `out_valid` is low one clock after `in_valid` is low. While `rst` is high, `out_valid`, `dst_new` and all flags are zero.
- R2: While `in_valid` is low, `dst_new` and the four flags keep their values, whatever the other inputs do.
- R3: Lane e of the packed 64-bit result (bits 16e+15..16e) is the conversion of source bits 32e+31..32e, for e = 0..3.
- R4: With `hi_sel` = 0, the packed result lands in `dst_new[63:0]` and `dst_new[127:64]` is zero.
- R5: With `hi_sel` = 1, the packed result lands in `dst_new[127:64]`, and `dst_new[63:0]` equals `dst_old[63:0]` as sampled with the operation.
- R6: With `rnd_mode` = 2'b00, rounding is to nearest. When the discarded 16 bits are exactly 0x8000, the result rounds to the value whose lowest kept bit is 0.
- R7: `rnd_mode` = 2'b01 rounds toward +infinity, 2'b10 toward -infinity and 2'b11 toward zero. A directed mode adds one to the magnitude only when the discarded bits are nonzero and the sign points in its direction.
- R8: A NaN input gives sign, exponent 0xFF, mantissa bit 6 set and mantissa bits 5..0 equal to input bits 21..16. `flg_invalid` is raised when input bit 22 is 0 (signalling NaN).
- R9: Infinities and zeros pass through as their upper 16 bits, with their sign kept and no flag raised.
- R10: With `ftz_en` = 1, a denormal input (exponent 0, mantissa nonzero) gives a signed zero and raises `flg_idenorm` without `flg_inexact`. With `ftz_en` = 0, it is rounded like a normal value.
- R11: When rounding carries a finite input to exponent 0xFF, the lane gives a signed infinity and raises both `flg_overflow` and `flg_inexact`.
- R12: `flg_inexact` is the OR over all lanes of "finite, not flushed, and discarded 16 bits nonzero".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| src_vec | input | 128 | Four single-precision source elements |
| dst_old | input | 128 | Previous destination contents |
| hi_sel | input | 1 | 0: write low half and clear high; 1: write high half and keep low |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward +inf, 10 toward -inf, 11 toward zero |
| ftz_en | input | 1 | Flush denormal inputs to signed zero |
| out_valid | output | 1 | Registered result valid |
| dst_new | output | 128 | New destination value |
| flg_invalid | output | 1 | Signalling NaN seen in any lane |
| flg_overflow | output | 1 | Rounding overflowed to infinity in any lane |
| flg_inexact | output | 1 | Nonzero bits discarded in any lane |
| flg_idenorm | output | 1 | Denormal input flushed in any lane |

## Verification
The bench uses the default parameters: four lanes, a 32-bit input format and a 16-bit output format. With these sizes, one packed word covers every lane position. The sweep walks all four rounding modes, both flush settings and both signs. It covers exponent classes zero, one, mid-range, largest finite and all-ones. For the discarded 16 bits it uses the patterns around the half point: zero, one, just below, exactly and just above half, and all ones. Each pattern lands in a different lane on every operation. This brings ties, carries into the exponent, overflow to infinity, both NaN kinds and denormals with and without flushing within reach, in both half-select forms.

// File: rtl/bfn_pkg.sv
package bfn_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_POS_INF = 2'b01,
    RM_NEG_INF = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic inexact;
    logic idenorm;
  } fpflags_t;

endpackage

// File: rtl/bfn_round_dec.sv
module bfn_round_dec #(
  parameter int DROP_W = 16
) (
  input  logic [1:0]        rm,
  input  logic              sgn,
  input  logic              keep_lsb,
  input  logic [DROP_W-1:0] drop,
  output logic              inc
);
  import bfn_pkg::*;

  logic half_bit;
  logic below_nz;
  logic any_nz;

  assign half_bit = drop[DROP_W-1];
  assign below_nz = |drop[DROP_W-2:0];
  assign any_nz   = |drop;

  always_comb begin
    unique case (rmode_e'(rm))
      RM_NEAREST: inc = half_bit & (below_nz | keep_lsb);
      RM_POS_INF: inc = ~sgn & any_nz;
      RM_NEG_INF: inc = sgn & any_nz;
      default:    inc = 1'b0;
    endcase
  end

endmodule

// File: rtl/bfn_lane_cvt.sv
module bfn_lane_cvt #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16,
  parameter int EXP_W = 8
) (
  input  logic [IN_W-1:0]    x,
  input  logic [1:0]         rm,
  input  logic               ftz,
  output logic [OUT_W-1:0]   res,
  output bfn_pkg::fpflags_t  fl
);
  localparam int IN_MAN  = IN_W - 1 - EXP_W;
  localparam int OUT_MAN = OUT_W - 1 - EXP_W;
  localparam int DROP_W  = IN_W - OUT_W;
  localparam int MAG_W   = OUT_W - 1;

  logic               sgn;
  logic [EXP_W-1:0]   expo;
  logic [IN_MAN-1:0]  man;
  logic               exp_max, exp_zero, man_nz;
  logic               is_nan, is_inf, is_zero, is_sub, flushed, finite_path;
  logic [MAG_W-1:0]   keep;
  logic [DROP_W-1:0]  drop;
  logic               inc;
  logic [MAG_W-1:0]   mag_rnd;
  logic               ovf;

  assign sgn      = x[IN_W-1];
  assign expo     = x[IN_W-2 -: EXP_W];
  assign man      = x[IN_MAN-1:0];
  assign exp_max  = &expo;
  assign exp_zero = ~|expo;
  assign man_nz   = |man;
  assign is_nan   = exp_max & man_nz;
  assign is_inf   = exp_max & ~man_nz;
  assign is_zero  = exp_zero & ~man_nz;
  assign is_sub   = exp_zero & man_nz;
  assign flushed  = is_sub & ftz;
  assign finite_path = ~exp_max & ~flushed;

  assign keep = x[IN_W-2:DROP_W];
  assign drop = x[DROP_W-1:0];

  bfn_round_dec #(.DROP_W(DROP_W)) u_rdec (
    .rm       (rm),
    .sgn      (sgn),
    .keep_lsb (keep[0]),
    .drop     (drop),
    .inc      (inc)
  );

  assign mag_rnd = keep + {{(MAG_W-1){1'b0}}, inc};
  assign ovf     = &mag_rnd[MAG_W-1:OUT_MAN];

  always_comb begin
    if (is_nan)
      res = {sgn, {EXP_W{1'b1}}, 1'b1, man[IN_MAN-2 -: OUT_MAN-1]};
    else if (is_inf || is_zero)
      res = {sgn, keep};
    else if (flushed)
      res = {sgn, {MAG_W{1'b0}}};
    else
      res = {sgn, mag_rnd};
  end

  always_comb begin
    fl.invalid  = is_nan & ~man[IN_MAN-1];
    fl.overflow = finite_path & ovf;
    fl.inexact  = finite_path & (|drop);
    fl.idenorm  = flushed;
  end

  always_comb begin
    if (is_nan) begin
      AST_NAN_QUIET: assert (res[OUT_MAN-1] && (&res[OUT_W-2:OUT_MAN])); // R8
    end
    if (flushed) begin
      AST_FTZ_SIGNED_ZERO: assert (res[MAG_W-1:0] == '0 && res[OUT_W-1] == x[IN_W-1] && !fl.inexact); // R10
    end
  end

endmodule

// File: rtl/bfn_half_insert.sv
module bfn_half_insert #(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0]   packed_res,
  input  logic [2*HALF_W-1:0] old_val,
  input  logic                hi_sel,
  output logic [2*HALF_W-1:0] new_val
);
  localparam logic [2*HALF_W-1:0] LO_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  logic [2*HALF_W-1:0] kept_lo;

  assign kept_lo = old_val & LO_MASK;

  always_comb begin
    if (hi_sel)
      new_val = {packed_res, {HALF_W{1'b0}}} | kept_lo;
    else
      new_val = {{HALF_W{1'b0}}, packed_res};
  end

endmodule

// File: rtl/bf16_narrow_unit.sv
module bf16_narrow_unit #(
  parameter int LANES = 4,
  parameter int IN_W  = 32,
  parameter int OUT_W = 16,
  parameter int EXP_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [LANES*IN_W-1:0]  src_vec,
  input  logic [2*LANES*OUT_W-1:0] dst_old,
  input  logic                   hi_sel,
  input  logic [1:0]             rnd_mode,
  input  logic                   ftz_en,
  output logic                   out_valid,
  output logic [2*LANES*OUT_W-1:0] dst_new,
  output logic                   flg_invalid,
  output logic                   flg_overflow,
  output logic                   flg_inexact,
  output logic                   flg_idenorm
);
  import bfn_pkg::*;

  localparam int HALF_W = LANES * OUT_W;
  localparam int DST_W  = 2 * HALF_W;

  logic [HALF_W-1:0] packed_res;
  fpflags_t          lane_fl [LANES];
  fpflags_t          fl_any;
  logic [DST_W-1:0]  merged;
  fpflags_t          fl_q;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    bfn_lane_cvt #(
      .IN_W  (IN_W),
      .OUT_W (OUT_W),
      .EXP_W (EXP_W)
    ) u_cvt (
      .x   (src_vec[e*IN_W +: IN_W]),
      .rm  (rnd_mode),
      .ftz (ftz_en),
      .res (packed_res[e*OUT_W +: OUT_W]),
      .fl  (lane_fl[e])
    );
  end

  always_comb begin
    fl_any = '0;
    for (int e = 0; e < LANES; e++)
      fl_any = fl_any | lane_fl[e];
  end

  bfn_half_insert #(.HALF_W(HALF_W)) u_ins (
    .packed_res (packed_res),
    .old_val    (dst_old),
    .hi_sel     (hi_sel),
    .new_val    (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_new   <= '0;
      fl_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_new <= merged;
        fl_q    <= fl_any;
      end
    end
  end

  assign flg_invalid  = fl_q.invalid;
  assign flg_overflow = fl_q.overflow;
  assign flg_inexact  = fl_q.inexact;
  assign flg_idenorm  = fl_q.idenorm;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dst_new) && $stable(fl_q))); // R2
  AST_LOW_CLEARS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hi_sel) |=> (dst_new[DST_W-1:HALF_W] == '0)); // R4
  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hi_sel) |=> (dst_new[HALF_W-1:0] == $past(dst_old[HALF_W-1:0]))); // R5
  AST_OVF_IMPLIES_INEXACT: assert property (@(posedge clk) disable iff (rst)
    flg_overflow |-> flg_inexact); // R11

endmodule

// File: tb/bf16_narrow_unit_test.sv
module bf16_narrow_unit_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, in_valid, hi_sel, ftz_en;
  logic [1:0]   rnd_mode;
  logic [127:0] src_vec, dst_old;
  logic         out_valid;
  logic [127:0] dst_new;
  logic         flg_invalid, flg_overflow, flg_inexact, flg_idenorm;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bf16_narrow_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .dst_old(dst_old), .hi_sel(hi_sel), .rnd_mode(rnd_mode), .ftz_en(ftz_en),
    .out_valid(out_valid), .dst_new(dst_new), .flg_invalid(flg_invalid),
    .flg_overflow(flg_overflow), .flg_inexact(flg_inexact), .flg_idenorm(flg_idenorm)
  );

  // flags packed as {invalid, overflow, inexact, idenorm}
  function automatic void ref_lane(input logic [31:0] x, input logic [1:0] rm, input logic ftz,
                                   output logic [15:0] r, output logic [3:0] fl);
    logic s;
    logic [7:0] e;
    logic [22:0] m;
    int unsigned mag, rem;
    logic up;
    s = x[31]; e = x[30:23]; m = x[22:0];
    fl = 4'b0000;
    if (e == 8'hFF && m != 0) begin
      r = {s, 8'hFF, 1'b1, m[21:16]};
      fl[3] = !m[22];
    end else if (e == 8'hFF || (e == 0 && m == 0)) begin
      r = x[31:16];
    end else if (e == 0 && ftz) begin
      r = {s, 15'h0};
      fl[0] = 1'b1;
    end else begin
      mag = x[30:16];
      rem = x[15:0];
      case (rm)
        2'b00:   up = (rem > 32768) || (rem == 32768 && (mag % 2) == 1);
        2'b01:   up = !s && rem != 0;
        2'b10:   up = s && rem != 0;
        default: up = 1'b0;
      endcase
      mag = mag + (up ? 1 : 0);
      if (mag >= 32640) fl[2] = 1'b1;
      fl[1] = (rem != 0);
      r = {s, mag[14:0]};
    end
  endfunction

  task automatic drive_check(input logic [127:0] s, input logic [127:0] o, input logic h,
                             input logic [1:0] rm, input logic f,
                             input logic [127:0] exp_dst, input logic [3:0] exp_fl,
                             input string req);
    logic [132:0] act, expv;
    @(negedge clk);
    src_vec = s; dst_old = o; hi_sel = h; rnd_mode = rm; ftz_en = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    act  = {out_valid, flg_invalid, flg_overflow, flg_inexact, flg_idenorm, dst_new};
    expv = {1'b1, exp_fl, exp_dst};
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic run_ref(input logic [127:0] s, input logic [127:0] o, input logic h,
                         input logic [1:0] rm, input logic f, input string req);
    logic [63:0]  res;
    logic [3:0]   fl, lf;
    logic [15:0]  r;
    logic [127:0] ed;
    fl = 4'b0000;
    for (int e = 0; e < 4; e++) begin
      ref_lane(s[32*e +: 32], rm, f, r, lf);
      res[16*e +: 16] = r;
      fl = fl | lf;
    end
    ed = h ? {res, o[63:0]} : {64'h0, res};
    drive_check(s, o, h, rm, f, ed, fl, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] snap;
    logic [3:0]   snapfl;
    logic [31:0]  lows [7];
    logic [6:0]   mhis [3];
    logic [7:0]   exps [5];
    int           opn;
    lows = '{32'h0000, 32'h0001, 32'h7FFF, 32'h8000, 32'h8001, 32'hFFFF, 32'h4000};
    mhis = '{7'h00, 7'h7F, 7'h35};
    exps = '{8'h00, 8'h01, 8'h7E, 8'hFE, 8'hFF};

    rst = 1'b1; in_valid = 1'b0; hi_sel = 1'b0; rnd_mode = 2'b00; ftz_en = 1'b0;
    src_vec = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if ({out_valid, flg_invalid, flg_overflow, flg_inexact, flg_idenorm, dst_new} !== 133'h0) begin
      n_bad++;
      $display("FAIL R1: reset actual %h expected 0",
               {out_valid, flg_invalid, flg_overflow, flg_inexact, flg_idenorm, dst_new});
    end
    rst = 1'b0;

    // R3 R4: lane order, known values, low form
    drive_check({32'h80000000, 32'h00000000, 32'hC0490FDB, 32'h3F800000}, {4{32'hDEADBEEF}},
                1'b0, 2'b00, 1'b0, {64'h0, 64'h8000_0000_C049_3F80}, 4'b0010, "R3 R4 lane order");
    // R6: ties to even
    drive_check({32'h3F818000, 32'h3F808000, 32'h3F808001, 32'h3F800000}, '0,
                1'b0, 2'b00, 1'b0, {64'h0, 64'h3F82_3F80_3F81_3F80}, 4'b0010, "R6 ties");
    // R7: directed modes
    drive_check({64'h0, 32'hBF800001, 32'h3F800001}, '0, 1'b0, 2'b01, 1'b0,
                {64'h0, 64'h0000_0000_BF80_3F81}, 4'b0010, "R7 toward +inf");
    drive_check({64'h0, 32'hBF800001, 32'h3F800001}, '0, 1'b0, 2'b10, 1'b0,
                {64'h0, 64'h0000_0000_BF81_3F80}, 4'b0010, "R7 toward -inf");
    drive_check({4{32'h7F7FFFFF}}, '0, 1'b0, 2'b11, 1'b0,
                {64'h0, {4{16'h7F7F}}}, 4'b0010, "R7 toward zero no overflow");
    // R11: overflow to infinity
    drive_check({4{32'h7F7FFFFF}}, '0, 1'b0, 2'b00, 1'b0,
                {64'h0, {4{16'h7F80}}}, 4'b0110, "R11 overflow");
    // R8 R9 R5: NaNs, infinity, zero, high form
    drive_check({32'h80000000, 32'h7F800000, 32'hFFC12345, 32'h7F800001},
                128'hAAAA_BBBB_CCCC_DDDD_1111_2222_3333_4444, 1'b1, 2'b00, 1'b0,
                {64'h8000_7F80_FFC1_7FC0, 64'h1111_2222_3333_4444}, 4'b1000, "R8 R9 R5 nan high");
    // R10: flush on and off
    drive_check({32'h3F800000, 32'h3F800000, 32'h80008000, 32'h00012345}, '0, 1'b0, 2'b00, 1'b1,
                {64'h0, 64'h3F80_3F80_8000_0000}, 4'b0001, "R10 flush on");
    drive_check({32'h3F800000, 32'h3F800000, 32'h80008000, 32'h00012345}, '0, 1'b0, 2'b00, 1'b0,
                {64'h0, 64'h3F80_3F80_8000_0001}, 4'b0010, "R10 flush off");
    // R12: inexact from one lane only
    drive_check({32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800001}, '0, 1'b0, 2'b11, 1'b0,
                {64'h0, {4{16'h3F80}}}, 4'b0010, "R12 one lane inexact");
    drive_check({4{32'h3F800000}}, '0, 1'b0, 2'b00, 1'b0,
                {64'h0, {4{16'h3F80}}}, 4'b0000, "R12 exact");

    // R2: idle hold
    drive_check({4{32'h7F800001}}, '0, 1'b0, 2'b00, 1'b0,
                {64'h0, {4{16'h7FC0}}}, 4'b1000, "R2 setup");
    snap = dst_new;
    snapfl = {flg_invalid, flg_overflow, flg_inexact, flg_idenorm};
    @(negedge clk);
    src_vec = {4{32'h7F7FFFFF}}; dst_old = {128{1'b1}}; hi_sel = 1'b1; rnd_mode = 2'b01; ftz_en = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (dst_new !== snap || {flg_invalid, flg_overflow, flg_inexact, flg_idenorm} !== snapfl || out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R2: idle actual %h/%b expected %h/%b", dst_new,
               {flg_invalid, flg_overflow, flg_inexact, flg_idenorm}, snap, snapfl);
    end

    // Sweep: R3 R6 R7 R8 R9 R10 R11 R12, both forms R4 R5
    opn = 0;
    for (int rm = 0; rm < 4; rm++)
      for (int f = 0; f < 2; f++)
        for (int sg = 0; sg < 2; sg++)
          for (int ei = 0; ei < 5; ei++)
            for (int mi = 0; mi < 3; mi++)
              for (int li = 0; li < 7; li++) begin
                logic [127:0] s, o;
                for (int e = 0; e < 4; e++) begin
                  logic [31:0] lw;
                  lw = lows[(li + e) % 7];
                  s[32*e +: 32] = {1'(sg ^ (e & 1)), exps[ei], mhis[(mi + e) % 3], lw[15:0]};
                end
                opn++;
                o = {4{32'(opn) * 32'h9E3779B9}};
                run_ref(s, o, 1'(li & 1), 2'(rm), 1'(f), "R3 R6 R7 R8 R9 R10 R11 R12 sweep");
              end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule